// File: doc/BRIEF.md
# Multichannel Hit Capture and Channel Identity Encoder

This block watches sixteen digital discriminator outputs and turns the first accepted hit into a channel identity for a downstream converter. Each hit line passes through a two-stage synchroniser and a rising-edge detector. When an edge arrives on a channel that is enabled, the block checks two conditions: its own lockout gate must be idle, and the external converter must not report busy. If both hold, the block sets that channel's hit flag and latches the channel number. The number is presented low-true on a 4-bit code output.

The channels are encoded by two identical 8-channel group encoders. When the upper group (channels 8 to 15) holds the winner, its 3-bit code together with a set group bit is steered into the identity register in place of the lower group's code. Each capture starts two timers. The busy timer drives an indicator. The gate timer locks out every channel while it runs. Each channel also has an active-low front-end control line. Holding it low keeps the channel from responding and clears that channel's flag, so external logic decides when each flag is reset.

Top module: `hit_route_encoder`

## Requirements
- R1: While `rst_n` is low, `hit_flags_o` is all zeros, `code_n_o` is 4'b1111, and `busy_o` and `lockout_o` are low. The reset takes effect without waiting for a clock edge.
- R2: A rising edge on `hit_i[k]` can be accepted. It is accepted when `fe_ctrl_n_i[k]` is high, `lockout_o` is low and `conv_busy_i` is low. Acceptance sets `hit_flags_o[k]` and makes `code_n_o` equal to the bitwise inverse of k. Both outputs become visible after the third rising clock edge that follows the input's rise.
- R3: When several eligible edges are detected in the same cycle, only the highest-numbered channel is captured. Only its flag is newly set. An upper-group channel therefore always beats a lower-group channel.
- R4: `code_n_o` keeps its value until the next accepted edge. A hit input that stays high produces no further capture.
- R5: `busy_o` rises with the capture and stays high for exactly BUSY_LEN clock cycles.
- R6: `lockout_o` rises with the capture and stays high for exactly GATE_LEN cycles. An edge detected while it is high is ignored: it sets no flag and leaves the code unchanged. Edges after the lockout ends are accepted again.
- R7: An edge detected while `conv_busy_i` is high is ignored. Acceptance resumes once the input is low.
- R8: While `fe_ctrl_n_i[k]` is low, channel k cannot be captured, and `hit_flags_o[k]` is cleared at the next clock edge. Other flags are unaffected, and a lower enabled channel that hits in the same cycle is captured instead.
- R9: A flag stays set across later captures of other channels until its front-end line clears it or reset occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| hit_i | input | 16 | Discriminator hit pulses, asynchronous |
| fe_ctrl_n_i | input | 16 | Per-channel front-end control, low blocks the channel and clears its flag |
| conv_busy_i | input | 1 | Converter busy level, synchronous to clk |
| hit_flags_o | output | 16 | Per-channel captured-hit flags |
| code_n_o | output | 4 | Latched channel identity, low-true |
| busy_o | output | 1 | Busy indicator pulse |
| lockout_o | output | 1 | Acceptance gate active |

## Verification
A wrong priority or a wrong group steer shows up on `code_n_o` three cycles after the hit, as a code that does not match the only newly set flag. A timer that is off by one changes the edge of `busy_o` or `lockout_o` by one cycle, and the bench samples that cycle on both sides. A lockout or converter-busy gate that leaks shows as an extra flag and a changed code a few cycles after the blocked edge. A held hit or a missing edge detector shows as a recapture after the lockout expires.

// File: rtl/hre_pkg.sv
package hre_pkg;
  // Number of flops in each input synchroniser chain.
  localparam int SYNC_STAGES = 2;
  // Number of channel groups that share the identity register.
  localparam int N_GROUPS    = 2;
endpackage

// File: rtl/hre_sync.sv
module hre_sync #(
  parameter int W      = 16,
  parameter int STAGES = hre_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hre_group_enc.sv
module hre_group_enc #(
  parameter int GRP = 8,
  localparam int GW = $clog2(GRP)
) (
  input  logic [GRP-1:0] onehot_i,
  output logic [GW-1:0]  code_o,
  output logic           any_o
);
  always_comb begin
    code_o = '0;
    for (int i = 0; i < GRP; i++) begin
      if (onehot_i[i]) code_o = code_o | GW'(i);
    end
    any_o = |onehot_i;
  end
endmodule

// File: rtl/hre_pulse_timer.sv
module hre_pulse_timer #(
  parameter int LEN = 8,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic active_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start_i || (cnt_q != '0);
    cnt_d  = start_i ? CW'(LEN) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);

  // R5 and R6: a start makes the pulse active on the next cycle
  a_r5_r6_start_active: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> active_o);
  // R5 and R6: the count never exceeds the programmed length
  a_r5_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LEN));
  // R5 and R6: the pulse only begins from a start
  a_r5_r6_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(start_i));
endmodule

// File: rtl/hit_route_encoder.sv
module hit_route_encoder #(
  parameter int N_CH     = 16,
  parameter int BUSY_LEN = 6,
  parameter int GATE_LEN = 10,
  localparam int GRP     = N_CH / hre_pkg::N_GROUPS,
  localparam int GW      = $clog2(GRP),
  localparam int IDW     = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] hit_i,
  input  logic [N_CH-1:0] fe_ctrl_n_i,
  input  logic            conv_busy_i,
  output logic [N_CH-1:0] hit_flags_o,
  output logic [IDW-1:0]  code_n_o,
  output logic            busy_o,
  output logic            lockout_o
);
  logic [N_CH-1:0] hit_s, hit_prev_q, rise;
  logic [N_CH-1:0] eligible, win;
  logic [N_CH-1:0] flags_q, flags_d;
  logic [IDW-1:0]  id_q, id_d;
  logic            accept_ok, accept;
  logic [hre_pkg::N_GROUPS-1:0][GW-1:0] grp_code;
  logic [hre_pkg::N_GROUPS-1:0]         grp_any;

  hre_sync #(.W(N_CH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(hit_i), .q_o(hit_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_prev_q <= '0;
    else        hit_prev_q <= hit_s;
  end

  // Edge detection and the acceptance gate.
  always_comb begin
    rise      = hit_s & ~hit_prev_q;
    accept_ok = !lockout_o && !conv_busy_i;
    eligible  = rise & fe_ctrl_n_i & {N_CH{accept_ok}};
    accept    = |eligible;
  end

  // Highest-numbered eligible channel wins.
  always_comb begin
    win = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (eligible[i] && (win == '0)) win[i] = 1'b1;
    end
  end

  // One encoder per channel group.
  for (genvar g = 0; g < hre_pkg::N_GROUPS; g++) begin : g_grp
    hre_group_enc #(.GRP(GRP)) u_enc (
      .onehot_i(win[g*GRP +: GRP]),
      .code_o  (grp_code[g]),
      .any_o   (grp_any[g])
    );
  end

  // Upper group code takes over the identity when it is active.
  always_comb begin
    if (grp_any[1]) id_d = {1'b1, grp_code[1]};
    else            id_d = {1'b0, grp_code[0]};
    flags_d = (flags_q | win) & fe_ctrl_n_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      id_q    <= '0;
    end else begin
      flags_q <= flags_d;
      if (accept) id_q <= id_d;
    end
  end

  hre_pulse_timer #(.LEN(BUSY_LEN)) u_busy (
    .clk(clk), .rst_n(rst_n), .start_i(accept), .active_o(busy_o)
  );
  hre_pulse_timer #(.LEN(GATE_LEN)) u_gate (
    .clk(clk), .rst_n(rst_n), .start_i(accept), .active_o(lockout_o)
  );

  assign hit_flags_o = flags_q;
  assign code_n_o    = ~id_q;

  // R3: at most one flag is newly set per cycle
  a_r3_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_flags_o & ~$past(hit_flags_o)));
  // R2: after a capture the flag named by the code is set
  a_r2_code_matches_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept) |-> hit_flags_o[~code_n_o]);
  // R4: the code changes only as a result of an accepted edge
  a_r4_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_n_o) |-> $past(accept));
  // R6: no flag is newly set while the lockout gate is active
  a_r6_lockout_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    lockout_o |=> ((hit_flags_o & ~$past(hit_flags_o)) == '0));
  // R7: no flag is newly set while the converter reports busy
  a_r7_conv_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy_i |=> ((hit_flags_o & ~$past(hit_flags_o)) == '0));
  // R8: a channel whose control line was low has no flag
  a_r8_fe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_flags_o & ~$past(fe_ctrl_n_i)) == '0);
endmodule

// File: tb/test_hit_route_encoder.sv
`timescale 1ns/1ps
module test_hit_route_encoder;
  localparam int N_CH = 16;
  localparam int BUSY_LEN = 6;
  localparam int GATE_LEN = 10;

  // {hit pattern, expected low-true code}
  localparam logic [19:0] VEC [8] = '{
    {16'h0001, 4'hF}, {16'h0080, 4'h8}, {16'h0100, 4'h7}, {16'h8001, 4'h0},
    {16'h0181, 4'h7}, {16'h00F0, 4'h8}, {16'h4000, 4'h1}, {16'h0006, 4'hD}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N_CH-1:0] hit_i, fe_ctrl_n_i;
  logic            conv_busy_i;
  logic [N_CH-1:0] hit_flags_o;
  logic [3:0]      code_n_o;
  logic            busy_o, lockout_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hit_route_encoder #(.N_CH(N_CH), .BUSY_LEN(BUSY_LEN), .GATE_LEN(GATE_LEN)) i_hit_route_encoder (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .fe_ctrl_n_i(fe_ctrl_n_i),
    .conv_busy_i(conv_busy_i), .hit_flags_o(hit_flags_o), .code_n_o(code_n_o),
    .busy_o(busy_o), .lockout_o(lockout_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Drive a pattern and return at the negedge after the capture edge.
  task automatic pulse(input logic [N_CH-1:0] v);
    @(negedge clk);
    hit_i = v;
    step(3);
  endtask

  task automatic clear_flags();
    @(negedge clk);
    fe_ctrl_n_i = '0;
    step(1);
    fe_ctrl_n_i = '1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hit_i = '0; fe_ctrl_n_i = '1; conv_busy_i = 1'b0;
    step(3);
    // R1 reset state
    chk("R1 flags", 32'(hit_flags_o), 32'h0);
    chk("R1 code", 32'(code_n_o), 32'hF);
    chk("R1 busy/lockout", {30'd0, busy_o, lockout_o}, 32'h0);
    rst_n = 1'b1;
    step(2);

    // R2 and R3: vector table, highest channel wins, group steer
    for (int k = 0; k < 8; k++) begin
      clear_flags();
      hit_i = '0;
      step(GATE_LEN + 3);
      pulse(VEC[k][19:4]);
      chk("R2/R3 code", 32'(code_n_o), 32'(VEC[k][3:0]));
      chk("R3 flags", 32'(hit_flags_o), 32'(16'h1 << (~VEC[k][3:0])));
      hit_i = '0;
    end

    // R5 busy length and R6 lockout length
    clear_flags();
    step(GATE_LEN + 3);
    pulse(16'h0002);
    hit_i = '0;
    chk("R5 busy rises", 32'(busy_o), 32'h1);
    chk("R6 lockout rises", 32'(lockout_o), 32'h1);
    step(BUSY_LEN - 1);
    chk("R5 busy last cycle", 32'(busy_o), 32'h1);
    step(1);
    chk("R5 busy ends", 32'(busy_o), 32'h0);
    step(GATE_LEN - 1 - BUSY_LEN);
    chk("R6 lockout last cycle", 32'(lockout_o), 32'h1);
    step(1);
    chk("R6 lockout ends", 32'(lockout_o), 32'h0);

    // R6 hit during lockout is ignored
    clear_flags();
    step(GATE_LEN + 3);
    pulse(16'h0008);
    hit_i = 16'h0400;
    step(4);
    chk("R6 ignored flag", 32'(hit_flags_o), 32'h0008);
    chk("R6 code kept", 32'(code_n_o), 32'hC);
    hit_i = '0;
    step(GATE_LEN);
    pulse(16'h0400);
    hit_i = '0;
    chk("R6 accepted after", 32'(code_n_o), 32'h5);

    // R7 converter busy blocks acceptance
    step(GATE_LEN + 3);
    conv_busy_i = 1'b1;
    pulse(16'h0020);
    hit_i = '0;
    step(2);
    chk("R7 blocked flag", 32'(hit_flags_o), 32'h0408);
    chk("R7 blocked code", 32'(code_n_o), 32'h5);
    conv_busy_i = 1'b0;
    step(1);
    pulse(16'h0020);
    hit_i = '0;
    chk("R7 resumed code", 32'(code_n_o), 32'hA);
    // R9 flags accumulate
    chk("R9 flags kept", 32'(hit_flags_o), 32'h0428);

    // R8 front-end line clears and blocks
    fe_ctrl_n_i[10] = 1'b0;
    step(1);
    chk("R8 clear", 32'(hit_flags_o), 32'h0028);
    step(GATE_LEN + 3);
    pulse(16'h0401);
    hit_i = '0;
    chk("R8 blocked ch wins not", 32'(code_n_o), 32'hF);
    chk("R8 flags", 32'(hit_flags_o), 32'h0029);
    fe_ctrl_n_i = '1;

    // R4 held hit does not retrigger
    clear_flags();
    step(GATE_LEN + 3);
    pulse(16'h1000);
    chk("R4 capture", 32'(code_n_o), 32'h3);
    step(GATE_LEN + 5);
    chk("R4 no retrigger", {31'd0, busy_o}, 32'h0);
    chk("R4 code held", 32'(code_n_o), 32'h3);
    pulse(16'h1004);
    chk("R4 new edge only", 32'(code_n_o), 32'hD);
    hit_i = '0;

    // R1 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async flags", 32'(hit_flags_o), 32'h0);
    chk("R1 async code", 32'(code_n_o), 32'hF);
    step(2);
    rst_n = 1'b1;
    step(2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule